// File: doc/BRIEF.md
# Interface Context Cache with Pinning

This block keeps a small, fully associative set of per-interface context records close to the packet pipeline. Each record carries the interface's handling mode, its priority and two buffer base addresses (receive and transmit). The authoritative copy of every record stays in system memory. Only the records of interfaces that are currently active live in the cache. A lookup by interface ID returns the record in the next cycle when it is present. When it is absent, the block sends one fetch request on a simple request/response memory port, installs the returned record and forwards it to the requester.

Critical interfaces can have their entries pinned. Replacement never selects a pinned entry, so those interfaces always hit with fixed latency. The unpinned ways are shared by every other interface under least-recently-used replacement. A management port writes records, which updates an entry in place or allocates one, and invalidates records. While one fetch is outstanding, lookups that hit are still served. A lookup that misses waits, so the same ID is never fetched twice. A fast hit leaves ample room inside a per-packet budget of 84 cycles.

Top module: `ctx_cache`

## Requirements
- R1: After reset no entry is valid, `rspValid` and `memReqValid` are low, and `lkReady` and `mgReady` are high.
- R2: A lookup accepted (`lkValid` and `lkReady` high at a clock edge) on a cached ID gives `rspValid`=1, `rspErr`=0, `rspId` equal to the ID and the stored record on `rspRec` in the next cycle. No memory request is issued.
- R3: An accepted lookup that misses raises `memReqValid` in the next cycle, with `memReqId` equal to the ID. The request stays high until a cycle with `memReqReady`=1. The cycle after `memRspValid`=1, the block gives `rspValid`=1, `rspErr`=0, the fetched ID and the returned record, and that record is installed.
- R4: A fill or allocating write takes an invalid way when one exists. Otherwise it replaces the unpinned entry that was hit, filled or written least recently.
- R5: A pinned entry is never evicted. A miss when every way is valid and pinned gives `rspValid`=1 and `rspErr`=1 in the next cycle, issues no request and changes no entry.
- R6: While a fetch is outstanding, a lookup that hits is accepted and answered as in R2. A lookup that misses is held with `lkReady`=0 and no second request is issued. `lkReady` is also 0 in the cycle that `memRspValid` is high.
- R7: A management write (`mgInval`=0) to a cached ID replaces its record and sets its pin to `mgPin` in place. To an uncached ID it allocates a way as in R4. With no way free it is dropped.
- R8: A management invalidate (`mgInval`=1) of a cached ID removes the entry and clears its pin, so the next lookup of that ID misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request valid |
| lkId | input | ID_W | Interface ID to look up |
| lkReady | output | 1 | Lookup can be accepted this cycle |
| mgValid | input | 1 | Management operation valid |
| mgInval | input | 1 | 1 = invalidate, 0 = write |
| mgPin | input | 1 | Pin value stored by a write |
| mgId | input | ID_W | Interface ID for management |
| mgRec | input | REC_W | Record stored by a write |
| mgReady | output | 1 | Management operation can be accepted |
| memReqValid | output | 1 | Fetch request to system memory |
| memReqId | output | ID_W | ID being fetched |
| memReqReady | input | 1 | Memory takes the request |
| memRspValid | input | 1 | Fetched record is present |
| memRspRec | input | REC_W | Fetched record |
| rspValid | output | 1 | Lookup response valid |
| rspErr | output | 1 | Miss could not be served, all ways pinned |
| rspId | output | ID_W | ID the response belongs to |
| rspRec | output | REC_W | Returned record |

## Verification
The hardest state to reach from the ports is a fetch held in flight while other traffic runs against the cache. A hit for a different ID must be served under the miss. A repeat lookup of the fetched ID must sit stalled without a second request. The response cycle must then block lookups and release the stalled lookup as a hit. A directed sequence holds the memory response back to build exactly this state and checks `lkReady` and `memReqValid` cycle by cycle. A fully pinned cache is built through management writes to force the error response. Seeded random lookups, writes and invalidates then run against a timestamp-based reference model, which checks LRU victim choice through the hit or miss result of later lookups.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int MODE_W = 2;
  localparam int PRIO_W = 3;
  localparam int ADDR_W = 32;
  localparam int REC_W  = MODE_W + PRIO_W + 2 * ADDR_W;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [PRIO_W-1:0] prio;
    logic [ADDR_W-1:0] rxBase;
    logic [ADDR_W-1:0] txBase;
  } ctxRec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rdHit;      // read hit way into response, touch it
    logic wrEn;       // write record (in place or allocate)
    logic wrFromMem;  // write source is the memory fill
    logic inval;      // invalidate management ID
  } ctxCmd_t;
endpackage

// File: rtl/ctx_store.sv
module ctx_store
  import ctx_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int ID_W     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctxCmd_t         cmd,
  input  logic [ID_W-1:0] lkId,
  input  logic [ID_W-1:0] mgId,
  input  logic            mgPin,
  input  ctxRec_t         mgRec,
  input  logic [ID_W-1:0] fetchId,
  input  ctxRec_t         memRec,
  output logic            lkHit,
  output logic            victimOk,
  output ctxRec_t         rspRec
);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  logic [NUM_WAYS-1:0] vld, pin;
  logic [ID_W-1:0]     tag [NUM_WAYS];
  ctxRec_t             rec [NUM_WAYS];
  logic [WAY_W-1:0]    age [NUM_WAYS];

  logic [NUM_WAYS-1:0] lkMatch, wrMatch, mgMatch;
  logic [ID_W-1:0]     wrId;
  logic [WAY_W-1:0]    lkWay, wrWay, mgWay, victim, wrTgt, touchWay;
  logic                wrHitAny, wrDo, touchEn, haveFree;
  logic [WAY_W-1:0]    bestAge;

  assign wrId = cmd.wrFromMem ? fetchId : mgId;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : gMatch
    assign lkMatch[g] = vld[g] && (tag[g] == lkId);
    assign wrMatch[g] = vld[g] && (tag[g] == wrId);
    assign mgMatch[g] = vld[g] && (tag[g] == mgId);
  end

  assign lkHit    = |lkMatch;
  assign wrHitAny = |wrMatch;

  always_comb begin
    lkWay = '0;
    wrWay = '0;
    mgWay = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (lkMatch[i]) lkWay = WAY_W'(i);
      if (wrMatch[i]) wrWay = WAY_W'(i);
      if (mgMatch[i]) mgWay = WAY_W'(i);
    end
  end

  // victim: lowest free way, else oldest unpinned way
  always_comb begin
    victim   = '0;
    victimOk = 1'b0;
    haveFree = 1'b0;
    bestAge  = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!vld[i] && !haveFree) begin
        haveFree = 1'b1;
        victimOk = 1'b1;
        victim   = WAY_W'(i);
      end
    end
    if (!haveFree) begin
      for (int i = 0; i < NUM_WAYS; i++) begin
        if (!pin[i] && (!victimOk || age[i] > bestAge)) begin
          victimOk = 1'b1;
          victim   = WAY_W'(i);
          bestAge  = age[i];
        end
      end
    end
  end

  assign wrTgt    = wrHitAny ? wrWay : victim;
  assign wrDo     = cmd.wrEn && (wrHitAny || victimOk);
  assign touchEn  = cmd.rdHit || wrDo;
  assign touchWay = cmd.rdHit ? lkWay : wrTgt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld    <= '0;
      pin    <= '0;
      rspRec <= '0;
      for (int i = 0; i < NUM_WAYS; i++) begin
        tag[i] <= '0;
        rec[i] <= '0;
        age[i] <= WAY_W'(i);
      end
    end else begin
      if (wrDo) begin
        vld[wrTgt] <= 1'b1;
        tag[wrTgt] <= wrId;
        rec[wrTgt] <= cmd.wrFromMem ? memRec : mgRec;
        pin[wrTgt] <= cmd.wrFromMem ? (wrHitAny && pin[wrTgt]) : mgPin;
      end
      if (cmd.inval && |mgMatch) begin
        vld[mgWay] <= 1'b0;
        pin[mgWay] <= 1'b0;
      end
      if (touchEn) begin
        for (int i = 0; i < NUM_WAYS; i++) begin
          if (WAY_W'(i) == touchWay) age[i] <= '0;
          else if (age[i] < age[touchWay]) age[i] <= age[i] + 1'b1;
        end
      end
      if (cmd.rdHit) rspRec <= rec[lkWay];
      else if (cmd.wrEn && cmd.wrFromMem) rspRec <= memRec;
    end
  end

  // an ID never sits in two ways (R7)
  p_tag_unique_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // control issues at most one array operation per cycle (R6)
  p_one_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.rdHit, cmd.wrEn, cmd.inval}));

  for (genvar g = 0; g < NUM_WAYS; g++) begin : gChk
    // pinned way survives everything except its own invalidate (R5)
    p_pin_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
      vld[g] && pin[g] && !(cmd.inval && mgMatch[g])
      |=> vld[g] && tag[g] == $past(tag[g]));
    // invalidate clears valid and pin (R8)
    p_inval_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
      cmd.inval && mgMatch[g] |=> !vld[g] && !pin[g]);
  end
endmodule

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic [ID_W-1:0] lkId,
  input  logic            lkHit,
  input  logic            victimOk,
  input  logic            mgValid,
  input  logic            mgInval,
  input  logic            memReqReady,
  input  logic            memRspValid,
  output logic            lkReady,
  output logic            mgReady,
  output ctxCmd_t         cmd,
  output logic [ID_W-1:0] fetchId,
  output logic            memReqValid,
  output logic            rspValid,
  output logic            rspErr,
  output logic [ID_W-1:0] rspId
);
  logic fetching, lkFire, mgFire, fillFire, startFetch, errOut;

  assign lkReady    = !mgValid && (!fetching || (lkHit && !memRspValid));
  assign mgReady    = !(fetching && memRspValid);
  assign lkFire     = lkValid && lkReady;
  assign mgFire     = mgValid && mgReady;
  assign fillFire   = fetching && memRspValid;
  assign startFetch = lkFire && !lkHit && victimOk;
  assign errOut     = lkFire && !lkHit && !victimOk;

  always_comb begin
    cmd           = '0;
    cmd.rdHit     = lkFire && lkHit;
    cmd.wrFromMem = fillFire;
    cmd.wrEn      = fillFire || (mgFire && !mgInval);
    cmd.inval     = mgFire && mgInval;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetching    <= 1'b0;
      memReqValid <= 1'b0;
      fetchId     <= '0;
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      rspId       <= '0;
    end else begin
      if (startFetch) begin
        fetching    <= 1'b1;
        memReqValid <= 1'b1;
        fetchId     <= lkId;
      end else begin
        if (fillFire)    fetching    <= 1'b0;
        if (memReqReady) memReqValid <= 1'b0;
      end
      rspValid <= cmd.rdHit || errOut || fillFire;
      rspErr   <= errOut;
      rspId    <= fillFire ? fetchId : lkId;
    end
  end

  p_hit_next_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkReady && lkHit |=> rspValid && !rspErr && rspId == $past(lkId));

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(fetchId));

  p_no_dup_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    fetching |=> !$rose(memReqValid));

  p_err_no_fetch_r5: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkReady && !lkHit && !victimOk |=> rspValid && rspErr && !memReqValid);
endmodule

// File: rtl/ctx_cache.sv
module ctx_cache
  import ctx_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int ID_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [ID_W-1:0]  lkId,
  output logic             lkReady,
  input  logic             mgValid,
  input  logic             mgInval,
  input  logic             mgPin,
  input  logic [ID_W-1:0]  mgId,
  input  logic [REC_W-1:0] mgRec,
  output logic             mgReady,
  output logic             memReqValid,
  output logic [ID_W-1:0]  memReqId,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic [REC_W-1:0] memRspRec,
  output logic             rspValid,
  output logic             rspErr,
  output logic [ID_W-1:0]  rspId,
  output logic [REC_W-1:0] rspRec
);
  ctxCmd_t         cmd;
  logic            lkHit, victimOk;
  logic [ID_W-1:0] fetchId;
  ctxRec_t         rspRecS;

  ctx_ctrl #(.ID_W(ID_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkId(lkId), .lkHit(lkHit),
    .victimOk(victimOk), .mgValid(mgValid), .mgInval(mgInval),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .lkReady(lkReady),
    .mgReady(mgReady), .cmd(cmd), .fetchId(fetchId), .memReqValid(memReqValid),
    .rspValid(rspValid), .rspErr(rspErr), .rspId(rspId)
  );

  ctx_store #(.NUM_WAYS(NUM_WAYS), .ID_W(ID_W)) uStore (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lkId(lkId), .mgId(mgId), .mgPin(mgPin),
    .mgRec(ctxRec_t'(mgRec)), .fetchId(fetchId), .memRec(ctxRec_t'(memRspRec)),
    .lkHit(lkHit), .victimOk(victimOk), .rspRec(rspRecS)
  );

  assign memReqId = fetchId;
  assign rspRec   = rspRecS;
endmodule

// File: tb/tb_ctx_cache.sv
module tb_ctx_cache;
  import ctx_pkg::*;
  localparam int WAYS = 4;
  localparam int IDW  = 4;
  localparam int NID  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic lkValid = 0, mgValid = 0, mgInval = 0, mgPin = 0;
  logic [IDW-1:0] lkId = '0, mgId = '0;
  logic [REC_W-1:0] mgRec = '0, memRspRec = '0;
  logic memReqReady = 0, memRspValid = 0;
  logic lkReady, mgReady, memReqValid, rspValid, rspErr;
  logic [IDW-1:0] memReqId, rspId;
  logic [REC_W-1:0] rspRec;

  ctx_cache #(.NUM_WAYS(WAYS), .ID_W(IDW)) dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkId(lkId), .lkReady(lkReady),
    .mgValid(mgValid), .mgInval(mgInval), .mgPin(mgPin), .mgId(mgId), .mgRec(mgRec),
    .mgReady(mgReady), .memReqValid(memReqValid), .memReqId(memReqId),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspRec(memRspRec),
    .rspValid(rspValid), .rspErr(rspErr), .rspId(rspId), .rspRec(rspRec)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: presence, pin, record and last-use stamp per ID
  bit mVld[NID];
  bit mPin[NID];
  logic [REC_W-1:0] mRec[NID];
  int mTime[NID];
  int now = 0;

  function automatic logic [REC_W-1:0] memOf(int id);
    return {MODE_W'(id), PRIO_W'(id * 3), ADDR_W'(32'h4000_0000 + id * 256),
            ADDR_W'(32'h8000_0000 + id * 64)};
  endfunction

  function automatic int mCount();
    int c = 0;
    for (int i = 0; i < NID; i++) if (mVld[i]) c++;
    return c;
  endfunction

  function automatic int mPins();
    int c = 0;
    for (int i = 0; i < NID; i++) if (mVld[i] && mPin[i]) c++;
    return c;
  endfunction

  // NID means a free way exists, -1 means nothing may be replaced
  function automatic int mVictim();
    int v = -1;
    if (mCount() < WAYS) return NID;
    for (int i = 0; i < NID; i++)
      if (mVld[i] && !mPin[i] && (v < 0 || mTime[i] < mTime[v])) v = i;
    return v;
  endfunction

  function automatic void mInstall(int id, logic [REC_W-1:0] r, bit p);
    int v = mVictim();
    if (v < 0) return;
    if (v < NID) begin mVld[v] = 0; mPin[v] = 0; end
    mVld[id] = 1; mPin[id] = p; mRec[id] = r;
    now++; mTime[id] = now;
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    for (int i = 0; i < NID; i++) begin mVld[i] = 0; mPin[i] = 0; mTime[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic doLookup(int id, string req);
    bit expHit, expErr;
    expHit = mVld[id];
    expErr = !expHit && (mVictim() < 0);
    @(negedge clk);
    lkValid = 1; lkId = IDW'(id); #1;
    while (!lkReady) begin @(negedge clk); #1; end
    @(negedge clk);
    lkValid = 0;
    if (expHit) begin
      chk(req, "hit response", {rspValid, rspErr}, 2'b10);
      chk(req, "hit issues no fetch", memReqValid, 0);
      chk(req, "hit record", rspRec, mRec[id]);
      chk(req, "hit id", rspId, id);
      now++; mTime[id] = now;
    end else if (expErr) begin
      chk("R5", "all-pinned miss error", {rspValid, rspErr}, 2'b11);
      chk("R5", "all-pinned miss no fetch", memReqValid, 0);
    end else begin
      chk(req, "miss gives no early response", rspValid, 0);
      chk("R3", "fetch raised", memReqValid, 1);
      chk("R3", "fetch id", memReqId, id);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk("R3", "request held until ready", memReqValid, 1);
      end
      memReqReady = 1;
      @(negedge clk);
      memReqReady = 0;
      chk("R3", "request dropped after ready", memReqValid, 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      memRspValid = 1; memRspRec = memOf(id);
      @(negedge clk);
      memRspValid = 0;
      chk(req, "fill response", {rspValid, rspErr}, 2'b10);
      chk(req, "fill record", rspRec, memOf(id));
      chk(req, "fill id", rspId, id);
      mInstall(id, memOf(id), 0);
    end
  endtask

  task automatic doMgmt(int id, bit inv, bit p, logic [REC_W-1:0] r);
    @(negedge clk);
    mgValid = 1; mgInval = inv; mgPin = p; mgId = IDW'(id); mgRec = r; #1;
    while (!mgReady) begin @(negedge clk); #1; end
    @(negedge clk);
    mgValid = 0;
    if (inv) begin
      mVld[id] = 0; mPin[id] = 0;
    end else if (mVld[id]) begin
      mRec[id] = r; mPin[id] = p; now++; mTime[id] = now;
    end else begin
      mInstall(id, r, p);
    end
  endtask

  function automatic logic [REC_W-1:0] rndRec();
    return REC_W'({$urandom(), $urandom(), $urandom()});
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    doReset();
    // R1 reset state
    chk("R1", "rspValid after reset", rspValid, 0);
    chk("R1", "memReqValid after reset", memReqValid, 0);
    chk("R1", "lkReady after reset", lkReady, 1);
    chk("R1", "mgReady after reset", mgReady, 1);
    doLookup(1, "R1");

    // R6 hit under miss, same-ID stall, no duplicate request
    @(negedge clk);
    lkValid = 1; lkId = 2; #1;
    chk("R6", "miss accepted when idle", lkReady, 1);
    @(negedge clk);
    lkValid = 0;
    chk("R6", "fetch raised", {memReqValid, memReqId}, {1'b1, 4'd2});
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    lkValid = 1; lkId = 1; #1;
    chk("R6", "hit accepted during fetch", lkReady, 1);
    @(negedge clk);
    lkValid = 0;
    chk("R6", "hit under miss response", {rspValid, rspErr, rspId}, {2'b10, 4'd1});
    chk("R6", "hit under miss record", rspRec, memOf(1));
    now++; mTime[1] = now;
    lkValid = 1; lkId = 2; #1;
    chk("R6", "same-ID miss stalled", lkReady, 0);
    repeat (3) begin
      @(negedge clk); #1;
      chk("R6", "stall holds", lkReady, 0);
      chk("R6", "no duplicate request", memReqValid, 0);
    end
    memRspValid = 1; memRspRec = memOf(2); #1;
    chk("R6", "lookup blocked in fill cycle", lkReady, 0);
    @(negedge clk);
    memRspValid = 0;
    chk("R6", "fill response", {rspValid, rspErr, rspId}, {2'b10, 4'd2});
    chk("R6", "fill record", rspRec, memOf(2));
    mInstall(2, memOf(2), 0);
    #1;
    chk("R6", "stalled lookup now hits", lkReady, 1);
    @(negedge clk);
    lkValid = 0;
    chk("R6", "released lookup response", {rspValid, rspErr, rspId}, {2'b10, 4'd2});
    chk("R6", "released lookup no fetch", memReqValid, 0);
    now++; mTime[2] = now;

    // R4 least recently used replacement
    doReset();
    for (int i = 0; i < 4; i++) doLookup(i, "R4");
    doLookup(0, "R4");
    doLookup(4, "R4");      // evicts ID 1
    chk("R4", "LRU victim gone", mVld[1], 0);
    doLookup(1, "R4");      // must miss, evicts ID 2
    doLookup(0, "R4");
    doLookup(3, "R4");

    // R5 pinning, R8 invalidate, R7 in-place write
    doReset();
    for (int i = 0; i < 4; i++) doMgmt(i, 0, 1, rndRec());
    doLookup(5, "R5");
    for (int i = 0; i < 4; i++) doLookup(i, "R5");
    doMgmt(2, 1, 0, '0);
    doLookup(2, "R8");
    doLookup(6, "R8");
    doLookup(0, "R5");
    doMgmt(3, 0, 0, rndRec());
    doLookup(3, "R7");
    doLookup(7, "R7");
    doLookup(3, "R7");
    doMgmt(9, 0, 0, rndRec());
    doLookup(9, "R7");

    // random mix against the model
    doReset();
    for (int n = 0; n < 700; n++) begin
      int op = $urandom_range(0, 9);
      int id = $urandom_range(0, 9);
      if (op <= 5) doLookup(id, "R2");
      else if (op <= 7) doMgmt(id, 0, (mPins() < WAYS - 1) && ($urandom_range(0, 3) == 0), rndRec());
      else begin
        doMgmt(id, 1, 0, '0);
        doLookup(id, "R8");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule